// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control section of a 12-bit successive-approximation converter with a classic read/convert processor interface. A falling edge on the read/convert line starts a conversion, but only while chip enable is high. The block then clears its approximation register and runs one trial bit per clock from the most significant bit down. It judges each trial from a single comparator bit supplied by the analog side, which sits outside this block.

Once a conversion has started it always runs to completion. A status output goes high a fixed number of clocks after the start. The final code is latched into an output register a fixed number of clocks before status drops, so a low status always means the latched data is valid.

The result is read over one 8-bit bus in two halves, chosen by a byte-select input. The bus drivers are enabled only while read/convert and chip enable are both high. The channel address is passed straight through to the analog multiplexer.

Top module: `sar_convert_ctrl`

## Requirements
- R1: A conversion starts only when read/convert is sampled low, having been high on the previous clock, while chipEn is high. A falling edge with chipEn low starts nothing, and status stays low.
- R2: At the start of a conversion the approximation register is cleared. On the first clock with status high, dacCode equals 12'h800, which is only the MSB trial set.
- R3: A started conversion cannot be aborted or restarted. Further read/convert edges during it leave the status timing and the final code unchanged.
- R4: Status rises exactly STAT_DLY clocks after the start edge. It stays high for 12 + LEAD_CYC clocks and is then low again.
- R5: The final code is latched LEAD_CYC clocks before status falls. While status is low and the read inputs are steady, the bus output does not change.
- R6: busOe is high only when readConv and chipEn are both high. When busOe is low, busOut is all zeros, which models a released bus.
- R7: With byteSel = 0 the bus carries result bits 11..4, with bit 11 on busOut[7]. With byteSel = 1 it carries result bits 3..0 on busOut[7:4], and busOut[3:0] = 0.
- R8: The result is plain binary. cmpIn = 1 means the input is at or above the current trial code, so the trial bit is kept. With an ideal comparator the result equals the input code, from 0 to 12'hFFF.
- R9: muxChan always equals chanAddr, combinationally.
- R10: If read/convert is held low after a conversion ends, no new conversion starts until a fresh high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | Chip enable; low blocks both read and convert |
| readConv | input | 1 | Read (high) / convert (falling edge) |
| byteSel | input | 1 | 0 selects the high byte, 1 selects the low nibble |
| chanAddr | input | 3 | Analog channel address |
| cmpIn | input | 1 | Comparator result for the current trial code |
| statusOut | output | 1 | High while a conversion is in progress |
| dacCode | output | 12 | Trial code presented to the DAC |
| muxChan | output | 3 | Channel select sent to the multiplexer |
| busOut | output | 8 | Data bus value |
| busOe | output | 1 | Data bus output enable |

## Verification
The hardest case to reach is the short window between the latch and the fall of status. There the new code must already be visible while status is still high. The bench reaches it by raising read/convert on exactly the clock after the LSB is resolved, then reading the high byte before status falls. A second hard case is a new falling edge in the middle of a conversion. The bench pulses read/convert high and low again during the bit sequence and checks that neither the status timing nor the code moves.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2,
    ST_LEAD = 2'd3
  } convState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearSar;
    logic seedMsb;
    logic resolve;
    logic latchOut;
  } sarStrobe_t;

endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int STAT_DLY = 20,
  parameter int LEAD_CYC = 50,
  localparam int IDX_W   = $clog2(RES_W),
  localparam int CNT_MAX = (STAT_DLY > LEAD_CYC) ? STAT_DLY : LEAD_CYC,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             readConv,
  output sarStrobe_t       strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic             statusOut
);

  localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_W - 1);

  convState_t       state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [IDX_W-1:0] idxNxt;
  logic             statusNxt;
  logic             rcPrev;
  logic             startEdge;

  // falling edge of read/convert, gated by chip enable, accepted only when idle
  assign startEdge = (state == ST_IDLE) && chipEn && rcPrev && !readConv;

  always_comb begin
    stateNxt  = state;
    cntNxt    = cnt;
    idxNxt    = bitIdx;
    statusNxt = statusOut;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (startEdge) begin
          stateNxt      = ST_WAIT;
          cntNxt        = '0;
          strb.clearSar = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cnt == CNT_W'(STAT_DLY - 1)) begin
          stateNxt     = ST_CONV;
          idxNxt       = MSB_IDX;
          strb.seedMsb = 1'b1;
          statusNxt    = 1'b1;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_CONV: begin
        strb.resolve = 1'b1;
        if (bitIdx == '0) begin
          strb.latchOut = 1'b1;
          stateNxt      = ST_LEAD;
          cntNxt        = '0;
        end else begin
          idxNxt = bitIdx - 1'b1;
        end
      end
      ST_LEAD: begin
        if (cnt == CNT_W'(LEAD_CYC - 1)) begin
          stateNxt  = ST_IDLE;
          statusNxt = 1'b0;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitIdx    <= '0;
      statusOut <= 1'b0;
      rcPrev    <= 1'b1;
    end else begin
      state     <= stateNxt;
      cnt       <= cntNxt;
      bitIdx    <= idxNxt;
      statusOut <= statusNxt;
      rcPrev    <= readConv;
    end
  end

endmodule

// File: rtl/sar_conv_datapath.sv
module sar_conv_datapath
  import sar_conv_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(RES_W),
  localparam int LO_W  = RES_W - DATA_W,
  localparam int PAD_W = DATA_W - LO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              cmpIn,
  input  logic              byteSel,
  input  logic              driveEn,
  output logic [RES_W-1:0]  dacCode,
  output logic [DATA_W-1:0] busOut
);

  logic [RES_W-1:0]  sarQ, keepVec, nextTrial, resultQ;
  logic [DATA_W-1:0] hiByte, loByte;

  // current trial bit replaced by the comparator decision
  always_comb begin
    keepVec         = sarQ;
    keepVec[bitIdx] = cmpIn;
  end

  assign nextTrial = (bitIdx != '0) ? (RES_W'(1) << (bitIdx - 1'b1)) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strb.clearSar)     sarQ <= '0;
      else if (strb.seedMsb) sarQ <= sarQ | (RES_W'(1) << (RES_W - 1));
      else if (strb.resolve) sarQ <= keepVec | nextTrial;
      if (strb.latchOut) resultQ <= keepVec;
    end
  end

  assign dacCode = sarQ;
  assign hiByte  = resultQ[RES_W-1 -: DATA_W];

  generate
    if (PAD_W > 0) begin : g_pad
      assign loByte = {resultQ[LO_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign loByte = resultQ[LO_W-1 -: DATA_W];
    end
  endgenerate

  assign busOut = !driveEn ? '0 : (byteSel ? loByte : hiByte);

endmodule

// File: rtl/sar_convert_ctrl.sv
module sar_convert_ctrl
  import sar_conv_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int DATA_W   = 8,
  parameter int CHAN_W   = 3,
  parameter int STAT_DLY = 20,
  parameter int LEAD_CYC = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              readConv,
  input  logic              byteSel,
  input  logic [CHAN_W-1:0] chanAddr,
  input  logic              cmpIn,
  output logic              statusOut,
  output logic [RES_W-1:0]  dacCode,
  output logic [CHAN_W-1:0] muxChan,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);

  localparam int IDX_W = $clog2(RES_W);

  sarStrobe_t       strb;
  logic [IDX_W-1:0] bitIdx;

  assign busOe   = chipEn && readConv;
  assign muxChan = chanAddr;

  sar_conv_ctrl #(
    .RES_W(RES_W), .STAT_DLY(STAT_DLY), .LEAD_CYC(LEAD_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .readConv(readConv),
    .strb(strb), .bitIdx(bitIdx), .statusOut(statusOut)
  );

  sar_conv_datapath #(
    .RES_W(RES_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx), .cmpIn(cmpIn),
    .byteSel(byteSel), .driveEn(busOe), .dacCode(dacCode), .busOut(busOut)
  );

endmodule

// File: rtl/sar_conv_checks.sv
module sar_conv_checks #(
  parameter int RES_W  = 12,
  parameter int DATA_W = 8,
  localparam int PAD_W = DATA_W - (RES_W - DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEn,
  input logic              readConv,
  input logic              byteSel,
  input logic              statusOut,
  input logic [RES_W-1:0]  dacCode,
  input logic [DATA_W-1:0] busOut
);

  localparam logic [RES_W-1:0] MSB_ONLY = RES_W'(1) << (RES_W - 1);

  a_r2_msb_seed: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut) |-> dacCode == MSB_ONLY);

  a_r6_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    !readConv |-> busOut == '0);

  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    byteSel |-> busOut[PAD_W-1:0] == '0);

  a_r5_result_held: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOut && $past(!statusOut) && $stable(byteSel) && $stable(readConv)
     && $stable(chipEn)) |-> $stable(busOut));

endmodule

bind sar_convert_ctrl sar_conv_checks #(.RES_W(RES_W), .DATA_W(DATA_W)) u_checks (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .readConv(readConv), .byteSel(byteSel),
  .statusOut(statusOut), .dacCode(dacCode), .busOut(busOut)
);

// File: tb/test_sar_convert_ctrl.sv
`timescale 1ns/1ps
module test_sar_convert_ctrl;

  localparam int S = 6;
  localparam int L = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEn = 1'b1;
  logic        readConv = 1'b1;
  logic        byteSel = 1'b0;
  logic [2:0]  chanAddr = 3'd0;
  logic        cmpIn;
  logic        statusOut;
  logic [11:0] dacCode;
  logic [2:0]  muxChan;
  logic [7:0]  busOut;
  logic        busOe;
  logic [11:0] tgt = 12'd0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // ideal comparator: keep trial bit when input >= trial code
  assign cmpIn = (tgt >= dacCode);

  sar_convert_ctrl #(.STAT_DLY(S), .LEAD_CYC(L)) i_sar_convert_ctrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .readConv(readConv), .byteSel(byteSel),
    .chanAddr(chanAddr), .cmpIn(cmpIn), .statusOut(statusOut), .dacCode(dacCode),
    .muxChan(muxChan), .busOut(busOut), .busOe(busOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readBack(input logic [11:0] expCode, input string req);
    readConv = 1'b1; byteSel = 1'b0; #1;
    check(busOut == expCode[11:4] && busOe, {req, "/R7 high byte"}, busOut, expCode[11:4]);
    byteSel = 1'b1; #1;
    check(busOut == {expCode[3:0], 4'b0}, {req, "/R7 low nibble"}, busOut, {expCode[3:0], 4'b0});
    byteSel = 1'b0;
  endtask

  // one conversion; optional mid-conversion pulse and early read
  task automatic runConv(input logic [11:0] code, input bit toggleMid, input bit readEarly);
    int badStat = 0;
    int badOe = 0;
    tgt = code;
    @(negedge clk) readConv = 1'b0;
    for (int k = 1; k <= S + 13 + L; k++) begin
      @(posedge clk); @(negedge clk);
      if (statusOut !== ((k >= S + 1) && (k <= S + 12 + L))) badStat++;
      if (!readConv && busOe) badOe++;
      if (k == S + 1)
        check(dacCode == 12'h800, "R2 MSB trial", dacCode, 12'h800);
      if (toggleMid && k == S + 3) readConv = 1'b1;
      if (toggleMid && k == S + 4) readConv = 1'b0;
      if (readEarly && k == S + 13) begin
        readConv = 1'b1; byteSel = 1'b0; #1;
        check(statusOut && busOut == code[11:4], "R5 latched before status low",
              {statusOut, busOut}, {1'b1, code[11:4]});
      end
    end
    check(badStat == 0, toggleMid ? "R3 status timing with edges" : "R4 status timing", badStat, 0);
    check(badOe == 0, "R6 no drive while convert low", badOe, 0);
    readBack(code, toggleMid ? "R3" : "R8");
  endtask

  task automatic tReset;
    #1;
    check(statusOut == 1'b0, "R4 reset status", statusOut, 0);
    check(busOut == 8'h00 && busOe, "R6 reset bus", busOut, 0);
  endtask

  task automatic tChipDisabled;
    @(negedge clk) chipEn = 1'b0; #1;
    check(!busOe && busOut == 8'h00, "R6 chip disabled release", {busOe, busOut}, 0);
    @(negedge clk) readConv = 1'b0;
    repeat (S + 4) @(negedge clk);
    check(statusOut == 1'b0, "R1 no start with chipEn low", statusOut, 0);
    readConv = 1'b1;
    @(negedge clk) chipEn = 1'b1;
    readBack(12'hA5C, "R1 result kept");
  endtask

  task automatic tHoldLow;
    tgt = 12'h3C1;
    @(negedge clk) readConv = 1'b0;
    repeat (S + 14 + L) @(negedge clk);
    check(statusOut == 1'b0, "R10 done", statusOut, 0);
    repeat (S + 4) @(negedge clk);
    check(statusOut == 1'b0, "R10 no restart while held low", statusOut, 0);
    readBack(12'h3C1, "R10");
  endtask

  task automatic tMux;
    for (int c = 0; c < 8; c++) begin
      chanAddr = 3'(c); #1;
      check(muxChan == 3'(c), "R9 channel pass-through", muxChan, c);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    runConv(12'hA5C, 1'b0, 1'b1);
    tChipDisabled();
    runConv(12'h000, 1'b0, 1'b0);
    runConv(12'hFFF, 1'b0, 1'b1);
    runConv(12'h001, 1'b1, 1'b0);
    runConv(12'h7FF, 1'b1, 1'b0);
    tHoldLow();
    tMux();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule